// File: doc/BRIEF.md
# Masked Interrupt Status Unit

This block gathers completion events from a four-sequencer data converter and turns them into level interrupts. Each sequencer raises a conversion-done event and a DMA-done event. A single comparator event is shared by all sequencers. Every event sets a sticky raw flag. A software-written mask selects which raw flags reach the readable status bits and the per-sequencer interrupt lines.

Software uses a small register bus with separate read and write strobes. It can read the raw flags, the mask and the masked status. It acknowledges sequencer and DMA events by writing ones to the status register. It acknowledges the comparator event through its own clear register. A status write clears the raw flag whether or not the flag is masked, so a driver that polls the raw register with interrupts disabled still has a way to acknowledge it.

Top module: `irq_status_unit`

## Requirements
- R1: Register words are selected by `bus_addr`: 0 is raw, 1 is mask, 2 is status, 3 is comparator-clear. Status bit k equals raw flag k AND mask bit k. Sequencer n sits at bit n, its DMA flag at bit 8+n and its comparator status at bit 16+n.
- R2: The raw word holds the sequencer flags in bits 0–3, the DMA flags in bits 8–11 and the single shared comparator flag in bit 16. Writes to the raw word are ignored.
- R3: Writing 1 to status bit n (0–3) or bit 8+n clears the matching raw flag, including when that bit is masked.
- R4: Status bits 16–19 are read-only. Writing to them leaves the comparator flag unchanged.
- R5: Writing 1 to any of bits 16–19 of the comparator-clear word clears the shared comparator flag.
- R6: Every bit outside 0–3, 8–11 and 16–19 reads as 0. A write to the mask stores only those defined bits.
- R7: After reset, all raw flags, the mask and the read data are 0.
- R8: `irq[n]` is the OR of status bits n, 8+n and 16+n. It stays high for as long as any one of them is set.
- R9: Writing 0 to any bit of the status or comparator-clear word has no effect.
- R10: When an event and a clear hit the same flag in the same cycle, the flag ends up set.
- R11: A read strobe loads `bus_rdata` at the next clock edge with the word as it stood before that edge. Without a strobe, `bus_rdata` holds its value. Word 3 reads as 0.
- R12: A raw flag stays set until it is cleared by a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| seq_done | input | 4 | Sequencer completion events, one per sequencer |
| dma_done | input | 4 | DMA completion events, one per sequencer |
| cmp_hit | input | 1 | Shared comparator event |
| bus_re | input | 1 | Read strobe |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 2 | Word select |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 4 | Level interrupt, one per sequencer |

## Verification
An event or a write presented before clock edge E changes the raw flags, and therefore the status and `irq`, just after E. A read strobed before E shows up on `bus_rdata` just after E, and it carries the state from before E. The bench drives its inputs one time unit after a rising edge. It advances a behavioural model at each rising edge, using those same inputs and the model's own earlier state. It then compares `irq` and `bus_rdata` with the model at every falling edge. The directed reads sample one time unit after the edge that loads `bus_rdata`, so every check lands in the cycle its result is due.

// File: rtl/irqsu_pkg.sv
package irqsu_pkg;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 2;
    localparam int SEQ_LSB = 0;
    localparam int DMA_LSB = 8;
    localparam int CMP_LSB = 16;

    typedef enum logic [ADDR_W-1:0] {
        REG_RAW  = 2'd0,
        REG_MASK = 2'd1,
        REG_STAT = 2'd2,
        REG_CCLR = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/irqsu_flag_bank.sv
module irqsu_flag_bank #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] flag_o
);
    typedef struct packed {
        logic [W-1:0] flag;
    } bank_t;

    bank_t s_d, s_q;

    // A clear is applied first and a set afterwards, so the set wins on a collision.
    always_comb begin
        s_d      = s_q;
        s_d.flag = (s_q.flag & ~clr_i) | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign flag_o = s_q.flag;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((flag_o & $past(set_i)) == $past(set_i))); // R10
    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_i & ~set_i)) |=> ((flag_o & $past(clr_i & ~set_i)) == '0)); // R3
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i == '0) |=> ((flag_o & $past(flag_o)) == $past(flag_o))); // R12
endmodule

// File: rtl/irqsu_mask_reg.sv
module irqsu_mask_reg #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we_i,
    input  logic [N-1:0] seq_i,
    input  logic [N-1:0] dma_i,
    input  logic [N-1:0] cmp_i,
    output logic [N-1:0] seq_o,
    output logic [N-1:0] dma_o,
    output logic [N-1:0] cmp_o
);
    typedef struct packed {
        logic [N-1:0] seq;
        logic [N-1:0] dma;
        logic [N-1:0] cmp;
    } mask_t;

    mask_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (we_i) begin
            s_d.seq = seq_i;
            s_d.dma = dma_i;
            s_d.cmp = cmp_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign seq_o = s_q.seq;
    assign dma_o = s_q.dma;
    assign cmp_o = s_q.cmp;

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> ($stable(seq_o) && $stable(dma_o) && $stable(cmp_o))); // R9
endmodule

// File: rtl/irqsu_wr_decode.sv
module irqsu_wr_decode
    import irqsu_pkg::*;
#(
    parameter int N = 4
) (
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              mask_we_o,
    output logic [N-1:0]      mask_seq_o,
    output logic [N-1:0]      mask_dma_o,
    output logic [N-1:0]      mask_cmp_o,
    output logic [N-1:0]      clr_seq_o,
    output logic [N-1:0]      clr_dma_o,
    output logic              clr_cmp_o
);
    localparam logic [DATA_W-1:0] FIELD_ONES = DATA_W'((64'd1 << N) - 64'd1);
    localparam logic [DATA_W-1:0] DEF_BITS =
        (FIELD_ONES << SEQ_LSB) | (FIELD_ONES << DMA_LSB) | (FIELD_ONES << CMP_LSB);

    // Reserved write bits are consumed here and go nowhere.
    logic unused_wdata;
    assign unused_wdata = ^(wdata_i & ~DEF_BITS);

    assign mask_seq_o = wdata_i[SEQ_LSB +: N];
    assign mask_dma_o = wdata_i[DMA_LSB +: N];
    assign mask_cmp_o = wdata_i[CMP_LSB +: N];

    always_comb begin
        mask_we_o = 1'b0;
        clr_seq_o = '0;
        clr_dma_o = '0;
        clr_cmp_o = 1'b0;
        if (we_i) begin
            case (reg_sel_e'(addr_i))
                REG_MASK: mask_we_o = 1'b1;
                REG_STAT: begin
                    // Bits CMP_LSB+ are read-only in this word and are not decoded.
                    clr_seq_o = wdata_i[SEQ_LSB +: N];
                    clr_dma_o = wdata_i[DMA_LSB +: N];
                end
                REG_CCLR: clr_cmp_o = |wdata_i[CMP_LSB +: N];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/irqsu_read_port.sv
module irqsu_read_port
    import irqsu_pkg::*;
#(
    parameter int N = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              re_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [N-1:0]      raw_seq_i,
    input  logic [N-1:0]      raw_dma_i,
    input  logic              raw_cmp_i,
    input  logic [N-1:0]      msk_seq_i,
    input  logic [N-1:0]      msk_dma_i,
    input  logic [N-1:0]      msk_cmp_i,
    input  logic [N-1:0]      st_seq_i,
    input  logic [N-1:0]      st_dma_i,
    input  logic [N-1:0]      st_cmp_i,
    output logic [DATA_W-1:0] rdata_o
);
    localparam logic [DATA_W-1:0] FIELD_ONES = DATA_W'((64'd1 << N) - 64'd1);
    localparam logic [DATA_W-1:0] DEF_BITS =
        (FIELD_ONES << SEQ_LSB) | (FIELD_ONES << DMA_LSB) | (FIELD_ONES << CMP_LSB);

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } rd_t;

    rd_t s_d, s_q;
    logic [DATA_W-1:0] word;

    always_comb begin
        word = '0;
        case (reg_sel_e'(addr_i))
            REG_RAW: begin
                for (int i = 0; i < N; i++) begin
                    word[SEQ_LSB + i] = raw_seq_i[i];
                    word[DMA_LSB + i] = raw_dma_i[i];
                end
                word[CMP_LSB] = raw_cmp_i;
            end
            REG_MASK: begin
                for (int i = 0; i < N; i++) begin
                    word[SEQ_LSB + i] = msk_seq_i[i];
                    word[DMA_LSB + i] = msk_dma_i[i];
                    word[CMP_LSB + i] = msk_cmp_i[i];
                end
            end
            REG_STAT: begin
                for (int i = 0; i < N; i++) begin
                    word[SEQ_LSB + i] = st_seq_i[i];
                    word[DMA_LSB + i] = st_dma_i[i];
                    word[CMP_LSB + i] = st_cmp_i[i];
                end
            end
            default: word = '0;
        endcase
    end

    always_comb begin
        s_d = s_q;
        if (re_i) s_d.rdata = word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rdata_o = s_q.rdata;

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata_o & ~DEF_BITS) == '0); // R6
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !re_i |=> $stable(rdata_o)); // R11
    AST_CCLR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (re_i && reg_sel_e'(addr_i) == REG_CCLR) |=> (rdata_o == '0)); // R11
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
    import irqsu_pkg::*;
#(
    parameter int N_SEQ = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SEQ-1:0]  seq_done,
    input  logic [N_SEQ-1:0]  dma_done,
    input  logic              cmp_hit,
    input  logic              bus_re,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [N_SEQ-1:0]  irq
);
    logic             mask_we;
    logic [N_SEQ-1:0] mask_seq_w, mask_dma_w, mask_cmp_w;
    logic [N_SEQ-1:0] clr_seq, clr_dma;
    logic             clr_cmp;
    logic [N_SEQ-1:0] raw_seq, raw_dma;
    logic [0:0]       raw_cmp;
    logic [N_SEQ-1:0] msk_seq, msk_dma, msk_cmp;
    logic [N_SEQ-1:0] st_seq, st_dma, st_cmp;

    irqsu_wr_decode #(.N(N_SEQ)) u_dec (
        .we_i       (bus_we),
        .addr_i     (bus_addr),
        .wdata_i    (bus_wdata),
        .mask_we_o  (mask_we),
        .mask_seq_o (mask_seq_w),
        .mask_dma_o (mask_dma_w),
        .mask_cmp_o (mask_cmp_w),
        .clr_seq_o  (clr_seq),
        .clr_dma_o  (clr_dma),
        .clr_cmp_o  (clr_cmp)
    );

    irqsu_mask_reg #(.N(N_SEQ)) u_mask (
        .clk   (clk),
        .rst_n (rst_n),
        .we_i  (mask_we),
        .seq_i (mask_seq_w),
        .dma_i (mask_dma_w),
        .cmp_i (mask_cmp_w),
        .seq_o (msk_seq),
        .dma_o (msk_dma),
        .cmp_o (msk_cmp)
    );

    irqsu_flag_bank #(.W(N_SEQ)) u_seq_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (seq_done),
        .clr_i  (clr_seq),
        .flag_o (raw_seq)
    );

    irqsu_flag_bank #(.W(N_SEQ)) u_dma_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (dma_done),
        .clr_i  (clr_dma),
        .flag_o (raw_dma)
    );

    irqsu_flag_bank #(.W(1)) u_cmp_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (cmp_hit),
        .clr_i  (clr_cmp),
        .flag_o (raw_cmp)
    );

    // Masked status: the one comparator flag fans out to every sequencer's field.
    always_comb begin
        st_seq = raw_seq & msk_seq;
        st_dma = raw_dma & msk_dma;
        st_cmp = {N_SEQ{raw_cmp[0]}} & msk_cmp;
    end

    genvar n;
    generate
        for (n = 0; n < N_SEQ; n++) begin : g_line
            assign irq[n] = st_seq[n] | st_dma[n] | st_cmp[n];

            AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
                irq[n] |-> (msk_seq[n] | msk_dma[n] | msk_cmp[n])); // R8
            AST_IRQ_NEEDS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
                irq[n] |-> (raw_seq[n] | raw_dma[n] | raw_cmp[0])); // R1
        end
    endgenerate

    irqsu_read_port #(.N(N_SEQ)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .re_i      (bus_re),
        .addr_i    (bus_addr),
        .raw_seq_i (raw_seq),
        .raw_dma_i (raw_dma),
        .raw_cmp_i (raw_cmp[0]),
        .msk_seq_i (msk_seq),
        .msk_dma_i (msk_dma),
        .msk_cmp_i (msk_cmp),
        .st_seq_i  (st_seq),
        .st_dma_i  (st_dma),
        .st_cmp_i  (st_cmp),
        .rdata_o   (bus_rdata)
    );

    AST_CMP_RO_IN_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && reg_sel_e'(bus_addr) == REG_STAT && !cmp_hit && raw_cmp[0]) |=> raw_cmp[0]); // R4
    AST_CCLR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && reg_sel_e'(bus_addr) == REG_CCLR && (|bus_wdata[CMP_LSB +: N_SEQ]) && !cmp_hit)
        |=> !raw_cmp[0]); // R5
    AST_RAW_WORD_RO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && reg_sel_e'(bus_addr) == REG_RAW) |=> ((raw_seq & $past(raw_seq)) == $past(raw_seq))); // R2
endmodule

// File: tb/irq_status_unit_tb.sv
`timescale 1ns/1ps
module irq_status_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  seq_done = '0;
    logic [3:0]  dma_done = '0;
    logic        cmp_hit = 1'b0;
    logic        bus_re = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    irq_status_unit u_dut (
        .clk(clk), .rst_n(rst_n), .seq_done(seq_done), .dma_done(dma_done),
        .cmp_hit(cmp_hit), .bus_re(bus_re), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    // Behavioural reference state
    bit [3:0]  m_seq, m_dma;
    bit        m_cmp;
    bit [31:0] m_mask, m_rd;

    function automatic bit [31:0] m_word(input int a);
        bit [31:0] w = 0;
        case (a)
            0: w = {15'd0, m_cmp, 4'd0, m_dma, 4'd0, m_seq};
            1: w = m_mask;
            2: w = {12'd0, {4{m_cmp}} & m_mask[19:16], 4'd0, m_dma & m_mask[11:8],
                    4'd0, m_seq & m_mask[3:0]};
            default: w = 0;
        endcase
        return w;
    endfunction

    function automatic bit [3:0] m_irq();
        bit [31:0] s = m_word(2);
        return s[3:0] | s[11:8] | s[19:16];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_seq = 0; m_dma = 0; m_cmp = 0; m_mask = 0; m_rd = 0;
        end else begin
            if (bus_re) m_rd = m_word(int'(bus_addr));
            if (bus_we) begin
                case (bus_addr)
                    2'd1: m_mask = bus_wdata & 32'h000F_0F0F;
                    2'd2: begin
                        m_seq = m_seq & ~bus_wdata[3:0];
                        m_dma = m_dma & ~bus_wdata[11:8];
                    end
                    2'd3: if (bus_wdata[19:16] != 0) m_cmp = 0;
                    default: ;
                endcase
            end
            m_seq = m_seq | seq_done;
            m_dma = m_dma | dma_done;
            m_cmp = m_cmp | cmp_hit;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R1 rdata vs model", bus_rdata, m_rd);
            chk("R8 irq vs model", {28'd0, irq}, {28'd0, m_irq()});
        end
    end

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(posedge clk); #1; bus_re = 1; bus_addr = a;
        @(posedge clk); #1; bus_re = 0; d = bus_rdata;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] v);
        @(posedge clk); #1; bus_we = 1; bus_addr = a; bus_wdata = v;
        @(posedge clk); #1; bus_we = 0; bus_wdata = 0;
    endtask

    task automatic pulse(input logic [3:0] s, input logic [3:0] dm, input logic c);
        @(posedge clk); #1; seq_done = s; dma_done = dm; cmp_hit = c;
        @(posedge clk); #1; seq_done = 0; dma_done = 0; cmp_hit = 0;
    endtask

    initial begin
        #1000000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, held;
        repeat (4) @(posedge clk);
        #1 rst_n = 1;
        // R7: reset state
        rd(2'd0, d); chk("R7 raw after reset", d, 32'h0);
        rd(2'd1, d); chk("R7 mask after reset", d, 32'h0);
        rd(2'd2, d); chk("R7 status after reset", d, 32'h0);
        chk("R7 irq after reset", {28'd0, irq}, 32'h0);

        // R12/R3: polling with everything masked
        pulse(4'b0001, 4'b0000, 1'b0);
        rd(2'd0, d); chk("R12 raw keeps seq0", d, 32'h1);
        rd(2'd2, d); chk("R1 masked status zero", d, 32'h0);
        chk("R8 irq masked off", {28'd0, irq}, 32'h0);
        wr(2'd2, 32'h1);
        rd(2'd0, d); chk("R3 masked clear", d, 32'h0);

        // R6: reserved mask bits
        wr(2'd1, 32'hFFFF_FFFF);
        rd(2'd1, d); chk("R6 mask defined bits only", d, 32'h000F_0F0F);
        // R2: raw word is read-only
        wr(2'd0, 32'hFFFF_FFFF);
        rd(2'd0, d); chk("R2 raw write ignored", d, 32'h0);

        pulse(4'b0100, 4'b0010, 1'b1);
        rd(2'd0, d); chk("R2 raw layout", d, 32'h0001_0204);
        rd(2'd2, d); chk("R1 status layout", d, 32'h000F_0204);
        chk("R8 all lines", {28'd0, irq}, 32'hF);

        wr(2'd2, 32'h000F_0000);
        rd(2'd0, d); chk("R4 cmp read-only in status", d, 32'h0001_0204);
        wr(2'd2, 32'h0);
        wr(2'd3, 32'h0);
        rd(2'd0, d); chk("R9 zero writes no effect", d, 32'h0001_0204);
        wr(2'd3, 32'h0002_0000);
        rd(2'd0, d); chk("R5 cmp clear", d, 32'h0000_0204);
        chk("R8 lines after cmp clear", {28'd0, irq}, 32'h6);

        wr(2'd1, 32'h0000_0004);
        chk("R8 only seq2 line", {28'd0, irq}, 32'h4);
        rd(2'd2, d); chk("R1 status with narrow mask", d, 32'h4);

        // R10: set and clear in the same cycle
        @(posedge clk); #1;
        bus_we = 1; bus_addr = 2'd2; bus_wdata = 32'h4; seq_done = 4'b0100;
        @(posedge clk); #1;
        bus_we = 0; bus_wdata = 0; seq_done = 0;
        rd(2'd0, d); chk("R10 set wins", d, 32'h0000_0204);
        wr(2'd2, 32'h0000_0204);
        rd(2'd0, d); chk("R3 clear seq and dma", d, 32'h0);

        // R11: hold and word 3
        rd(2'd1, held);
        repeat (3) @(posedge clk);
        #1 chk("R11 rdata holds", bus_rdata, held);
        rd(2'd3, d); chk("R11 word 3 reads zero", d, 32'h0);

        // Random traffic, compared against the model every cycle
        wr(2'd1, 32'h000F_0F0F);
        for (int i = 0; i < 600; i++) begin
            @(posedge clk); #1;
            seq_done  = ($urandom % 4 == 0) ? 4'($urandom) : 4'h0;
            dma_done  = ($urandom % 4 == 0) ? 4'($urandom) : 4'h0;
            cmp_hit   = ($urandom % 8 == 0);
            bus_re    = $urandom % 2;
            bus_we    = ($urandom % 3 == 0);
            bus_addr  = 2'($urandom);
            bus_wdata = $urandom;
        end
        @(posedge clk); #1;
        seq_done = 0; dma_done = 0; cmp_hit = 0; bus_re = 0; bus_we = 0;
        repeat (2) @(posedge clk);
        #1;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule